// File: doc/BRIEF.md
# Core Module System Control Registers

This block is the system-control register file of a processor core module. A host reaches it over a plain word-addressed register bus: one read strobe, one write strobe, a byte address whose two low bits are ignored, write data, and registered read data with an error strobe. The registers hold the main and auxiliary oscillator words, a 16-bit unlock key, a control word, SDRAM and init configuration, and two flag words with separate set and clear addresses. A read-only window returns the bytes of a serial-presence-detect table.

The oscillator words accept a write only while the unlock key holds its magic value. The control word drives two outputs: one lights the misc LED, the other moves RAM to address zero in place of boot flash. A separate data bit in a control write raises a one-cycle reset request, and that bit is never stored. Any access to an address the block does not implement returns zero, raises the error strobe and changes nothing.

Top module: `core_ctrl_regs`

## Requirements
- R1: Word index is the byte address shifted right by 2. A read of index 0 returns 0x411A3001, index 1 returns 0, and index 4 returns 0x00100000. Read data is registered: it appears in the cycle after the read strobe, and any cycle with no read strobe presents zero.
- R2: A write to index 5 stores data bits 15:0 as the unlock key. A read of index 5 returns 0x0001A05F while the key equals 0xA05F, and the stored key zero-extended otherwise.
- R3: Writes to the main oscillator word (index 2) and the auxiliary oscillator word (index 7) update them only while the key equals 0xA05F. Otherwise the write is ignored and raises no error.
- R4: A write to index 3 loads control bits 0 and 2 from the data; every other bit of the index-3 read value is zero. Data bit 3 of that write drives `rst_req` high for exactly the following cycle.
- R5: `led_on` follows control bit 0 and `remap_ram` follows control bit 2. Value 0 of `remap_ram` keeps boot flash at address zero, and value 1 puts RAM there. Both change only after a write to index 3.
- R6: Index 12 reads the flag word. A write to index 12 ORs the data into it, and a write to index 13 clears the bits set in the data.
- R7: Index 14 reads the non-volatile flag word. A write to index 14 sets bits, and a write to index 15 clears them, in the same way as R6.
- R8: Index 8 (SDRAM configuration) and index 9 (init configuration) are fully writable 32-bit words.
- R9: Byte addresses 0x100 + 4k, k = 0..31, return table entry k in bits 7:0 with the upper bits zero. Entry 0 is 0x80, entry 2 is 0x04, entry 9 is 0xA0, and entry 31 is the parameter `SPD_LAST` (default 0x02). Byte addresses 0x180 to 0x1FF read zero. Writes anywhere in 0x100 to 0x1FF are unimplemented.
- R10: Indexes 32 to 35 read as zero. Writes to them are accepted, raise no error and change nothing.
- R11: A read of an index outside the readable set {0-5, 7-9, 12, 14, 32-35, 64-127}, or a write to an index outside the writable set {2, 3, 5, 7-9, 12-15, 32-35}, drives `rsp_err` high for the cycle after the access, returns zero read data and changes no register.
- R12: After reset the main oscillator reads 0x01000048, the auxiliary oscillator 0x0007FEFF, SDRAM 0x00011122, init 0x00000112, and the control word, key and both flag words read zero. `rst_req`, `remap_ram` and `led_on` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_rd | input | 1 | Read strobe for one cycle |
| req_wr | input | 1 | Write strobe for one cycle |
| req_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data, valid in the cycle after `req_rd` |
| rsp_err | output | 1 | One-cycle strobe for an unimplemented access |
| rst_req | output | 1 | One-cycle reset request |
| remap_ram | output | 1 | 1: RAM at address zero; 0: boot flash at address zero |
| led_on | output | 1 | Misc LED drive |

## Verification
The bound checker watches several properties on every cycle. Reset-request pulses follow only control writes that carry bit 3. The LED and remap outputs hold still when no control write happens. The error strobe always comes with zero data, idle cycles present zero data, the ID read returns its constant, and the lock read never sets bits above 16. The lock-gated oscillator writes, the set and clear accumulation of both flag words, the table contents and its zero upper half, and the rule that a rejected write leaves every register untouched all depend on a history of accesses. Only the bench scenarios show those, with the bench's behavioural model compared against the outputs on each clock.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int WORD_W = 32;
  localparam int KEY_W  = 16;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t ID_VAL   = 32'h411A3001;
  localparam word_t STAT_VAL = 32'h00100000;
  localparam word_t OSC_RST  = 32'h01000048;
  localparam word_t AUX_RST  = 32'h0007FEFF;
  localparam word_t SDR_RST  = 32'h00011122;
  localparam word_t INIT_RST = 32'h00000112;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA05F;

  // word indexes whose positions software decodes
  localparam int IX_ID      = 0;
  localparam int IX_PROC    = 1;
  localparam int IX_OSC     = 2;
  localparam int IX_CTRL    = 3;
  localparam int IX_STAT    = 4;
  localparam int IX_KEY     = 5;
  localparam int IX_AUX     = 7;
  localparam int IX_SDR     = 8;
  localparam int IX_INIT    = 9;
  localparam int IX_FLG_S   = 12;
  localparam int IX_FLG_C   = 13;
  localparam int IX_NVF_S   = 14;
  localparam int IX_NVF_C   = 15;
  localparam int IX_VOLT_LO = 32;
  localparam int IX_VOLT_HI = 35;
  localparam int IX_SPD_LO  = 64;
  localparam int IX_SPD_HI  = 127;
  localparam int SPD_ENTRIES = 32;

  localparam int CB_LED   = 0;
  localparam int CB_REMAP = 2;
  localparam int CB_RSTRQ = 3;

  function automatic logic [7:0] spd_byte(input int k, input logic [7:0] last);
    case (k)
      0: return 8'd128;  1: return 8'd8;    2: return 8'd4;    3: return 8'd11;
      4: return 8'd9;    5: return 8'd1;    6: return 8'd64;   8: return 8'd2;
      9: return 8'hA0;  10: return 8'hA0;  13: return 8'd8;   15: return 8'd1;
      16: return 8'h0E; 17: return 8'd4;   18: return 8'h1C;  19: return 8'd1;
      20: return 8'd2;  21: return 8'h20;  22: return 8'hC0;  27: return 8'h30;
      28: return 8'h28; 29: return 8'h30;  30: return 8'h28;  31: return last;
      default: return 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/ccr_key_gate.sv
module ccr_key_gate import ccr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_we,
  input  logic              osc_we,
  input  logic              aux_we,
  input  word_t             wdata,
  output logic [KEY_W-1:0]  key_q,
  output logic              unlocked,
  output word_t             osc_q,
  output word_t             aux_q
);
  logic [KEY_W-1:0] key_d;
  word_t osc_d, aux_d;

  assign unlocked = (key_q == UNLOCK_KEY);

  always_comb begin
    key_d = key_we ? wdata[KEY_W-1:0] : key_q;
    osc_d = (osc_we && unlocked) ? wdata : osc_q;
    aux_d = (aux_we && unlocked) ? wdata : aux_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      osc_q <= OSC_RST;
      aux_q <= AUX_RST;
    end else begin
      key_q <= key_d;
      osc_q <= osc_d;
      aux_q <= aux_d;
    end
  end
endmodule

// File: rtl/ccr_setclr_reg.sv
module ccr_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb begin
    d = q;
    if (set_en) d = d | wdata;
    if (clr_en) d = d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/ccr_spd_rom.sv
module ccr_spd_rom import ccr_pkg::*; #(
  parameter int         ENTRIES = SPD_ENTRIES,
  parameter logic [7:0] LAST    = 8'h02,
  localparam int        SEL_W   = $clog2(ENTRIES)
) (
  input  logic [SEL_W-1:0] sel,
  output logic [7:0]       q
);
  logic [7:0] tbl [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign tbl[g] = spd_byte(g, LAST);
  end

  assign q = tbl[sel];
endmodule

// File: rtl/core_ctrl_regs.sv
module core_ctrl_regs import ccr_pkg::*; #(
  parameter int         ADDR_W   = 12,
  parameter logic [7:0] SPD_LAST = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              rst_req,
  output logic              remap_ram,
  output logic              led_on
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int SEL_W = $clog2(SPD_ENTRIES);

  logic [IDX_W-1:0] idx;
  logic [1:0]       unused_lo;
  assign idx       = req_addr[ADDR_W-1:2];
  assign unused_lo = req_addr[1:0];

  function automatic logic is_ix(input logic [IDX_W-1:0] i, input int ix);
    return i == IDX_W'(ix);
  endfunction

  // write strobes
  logic we_osc, we_ctrl, we_key, we_aux, we_sdr, we_init;
  logic we_fs, we_fc, we_ns, we_nc;
  always_comb begin
    we_osc  = req_wr && is_ix(idx, IX_OSC);
    we_ctrl = req_wr && is_ix(idx, IX_CTRL);
    we_key  = req_wr && is_ix(idx, IX_KEY);
    we_aux  = req_wr && is_ix(idx, IX_AUX);
    we_sdr  = req_wr && is_ix(idx, IX_SDR);
    we_init = req_wr && is_ix(idx, IX_INIT);
    we_fs   = req_wr && is_ix(idx, IX_FLG_S);
    we_fc   = req_wr && is_ix(idx, IX_FLG_C);
    we_ns   = req_wr && is_ix(idx, IX_NVF_S);
    we_nc   = req_wr && is_ix(idx, IX_NVF_C);
  end

  logic [KEY_W-1:0] key_q;
  logic             unlocked;
  word_t            osc_q, aux_q, flg_q, nvf_q;

  ccr_key_gate u_key (
    .clk(clk), .rst_n(rst_n), .key_we(we_key), .osc_we(we_osc), .aux_we(we_aux),
    .wdata(req_wdata), .key_q(key_q), .unlocked(unlocked), .osc_q(osc_q), .aux_q(aux_q)
  );

  ccr_setclr_reg #(.W(WORD_W)) u_flg (
    .clk(clk), .rst_n(rst_n), .set_en(we_fs), .clr_en(we_fc), .wdata(req_wdata), .q(flg_q)
  );

  ccr_setclr_reg #(.W(WORD_W)) u_nvf (
    .clk(clk), .rst_n(rst_n), .set_en(we_ns), .clr_en(we_nc), .wdata(req_wdata), .q(nvf_q)
  );

  logic [7:0] spd_q;
  ccr_spd_rom #(.ENTRIES(SPD_ENTRIES), .LAST(SPD_LAST)) u_spd (
    .sel(idx[SEL_W-1:0]), .q(spd_q)
  );

  // plain configuration words and control bits
  word_t sdr_q, sdr_d, init_q, init_d;
  logic  led_q, led_d, rmp_q, rmp_d;
  logic  rst_d;

  always_comb begin
    sdr_d  = we_sdr  ? req_wdata : sdr_q;
    init_d = we_init ? req_wdata : init_q;
    led_d  = we_ctrl ? req_wdata[CB_LED]   : led_q;
    rmp_d  = we_ctrl ? req_wdata[CB_REMAP] : rmp_q;
    rst_d  = we_ctrl && req_wdata[CB_RSTRQ];
  end

  // read decode
  logic  rd_ok, wr_ok, in_volt, in_spd, in_tab;
  word_t rd_mux;

  always_comb begin
    in_volt = (idx >= IDX_W'(IX_VOLT_LO)) && (idx <= IDX_W'(IX_VOLT_HI));
    in_spd  = (idx >= IDX_W'(IX_SPD_LO))  && (idx <= IDX_W'(IX_SPD_HI));
    in_tab  = in_spd && (idx < IDX_W'(IX_SPD_LO + SPD_ENTRIES));
    rd_ok   = in_volt || in_spd;
    wr_ok   = in_volt;
    rd_mux  = '0;
    if (in_tab) rd_mux = {{(WORD_W-8){1'b0}}, spd_q};
    case (idx)
      IDX_W'(IX_ID):    begin rd_ok = 1'b1; rd_mux = ID_VAL; end
      IDX_W'(IX_PROC):  rd_ok = 1'b1;
      IDX_W'(IX_OSC):   begin rd_ok = 1'b1; wr_ok = 1'b1; rd_mux = osc_q; end
      IDX_W'(IX_CTRL):  begin
        rd_ok = 1'b1; wr_ok = 1'b1;
        rd_mux[CB_LED] = led_q; rd_mux[CB_REMAP] = rmp_q;
      end
      IDX_W'(IX_STAT):  begin rd_ok = 1'b1; rd_mux = STAT_VAL; end
      IDX_W'(IX_KEY):   begin
        rd_ok = 1'b1; wr_ok = 1'b1;
        rd_mux = {{(WORD_W-KEY_W-1){1'b0}}, unlocked, key_q};
      end
      IDX_W'(IX_AUX):   begin rd_ok = 1'b1; wr_ok = 1'b1; rd_mux = aux_q; end
      IDX_W'(IX_SDR):   begin rd_ok = 1'b1; wr_ok = 1'b1; rd_mux = sdr_q; end
      IDX_W'(IX_INIT):  begin rd_ok = 1'b1; wr_ok = 1'b1; rd_mux = init_q; end
      IDX_W'(IX_FLG_S): begin rd_ok = 1'b1; wr_ok = 1'b1; rd_mux = flg_q; end
      IDX_W'(IX_FLG_C): wr_ok = 1'b1;
      IDX_W'(IX_NVF_S): begin rd_ok = 1'b1; wr_ok = 1'b1; rd_mux = nvf_q; end
      IDX_W'(IX_NVF_C): wr_ok = 1'b1;
      default: ;
    endcase
  end

  word_t rdata_d;
  logic  err_d;
  always_comb begin
    rdata_d = (req_rd && rd_ok) ? rd_mux : '0;
    err_d   = (req_rd && !rd_ok) || (req_wr && !wr_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdr_q     <= SDR_RST;
      init_q    <= INIT_RST;
      led_q     <= 1'b0;
      rmp_q     <= 1'b0;
      rst_req   <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      sdr_q     <= sdr_d;
      init_q    <= init_d;
      led_q     <= led_d;
      rmp_q     <= rmp_d;
      rst_req   <= rst_d;
      rsp_rdata <= rdata_d;
      rsp_err   <= err_d;
    end
  end

  assign led_on    = led_q;
  assign remap_ram = rmp_q;
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker import ccr_pkg::*; #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_rd,
  input logic              req_wr,
  input logic [ADDR_W-1:0] req_addr,
  input logic [WORD_W-1:0] req_wdata,
  input logic [WORD_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              rst_req,
  input logic              remap_ram,
  input logic              led_on
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] c_idx;
  logic ctrl_wr, rq_wr, id_rd, key_rd;
  assign c_idx   = req_addr[ADDR_W-1:2];
  assign ctrl_wr = req_wr && (c_idx == IDX_W'(IX_CTRL));
  assign rq_wr   = ctrl_wr && req_wdata[CB_RSTRQ];
  assign id_rd   = req_rd && (c_idx == IDX_W'(IX_ID));
  assign key_rd  = req_rd && (c_idx == IDX_W'(IX_KEY));

  AST_RSTREQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rq_wr |=> rst_req); // R4
  AST_RSTREQ_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !rq_wr |=> !rst_req); // R4
  AST_REMAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(remap_ram)); // R5
  AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(led_on)); // R5
  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    id_rd |=> (rsp_rdata == ID_VAL)); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rd |=> (rsp_rdata == '0)); // R1
  AST_KEY_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    key_rd |=> (rsp_rdata[WORD_W-1:KEY_W+1] == '0)); // R2
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0)); // R11
endmodule

bind core_ctrl_regs ccr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_addr(req_addr),
  .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rst_req(rst_req),
  .remap_ram(remap_ram), .led_on(led_on)
);

// File: tb/core_ctrl_regs_tb_top.sv
module core_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_rd = 1'b0, req_wr = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_err, rst_req, remap_ram, led_on;

  always #2 clk = ~clk;

  core_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rst_req(rst_req),
    .remap_ram(remap_ram), .led_on(led_on)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0, cmp_en = 0;
  string cur_req = "R12";

  // behavioural reference model
  logic [31:0] m_osc, m_aux, m_sdr, m_init, m_flg, m_nvf, m_ctrl;
  logic [15:0] m_key;
  logic [31:0] e_rd;
  logic        e_err, e_rst;
  byte unsigned spd [32];

  initial begin
    foreach (spd[i]) spd[i] = 0;
    spd[0]=128; spd[1]=8; spd[2]=4; spd[3]=11; spd[4]=9; spd[5]=1; spd[6]=64;
    spd[8]=2; spd[9]=8'hA0; spd[10]=8'hA0; spd[13]=8; spd[15]=1; spd[16]=8'h0E;
    spd[17]=4; spd[18]=8'h1C; spd[19]=1; spd[20]=2; spd[21]=8'h20; spd[22]=8'hC0;
    spd[27]=8'h30; spd[28]=8'h28; spd[29]=8'h30; spd[30]=8'h28; spd[31]=8'h02;
  end

  function automatic logic [32:0] mread(input logic [11:0] a);
    int ix = int'(a >> 2);
    if (ix >= 64 && ix < 96) return {1'b1, 24'd0, spd[ix-64]};
    if ((ix >= 96 && ix < 128) || (ix >= 32 && ix <= 35)) return {1'b1, 32'd0};
    case (ix)
      0: return {1'b1, 32'h411A3001};
      1: return {1'b1, 32'd0};
      2: return {1'b1, m_osc};
      3: return {1'b1, m_ctrl};
      4: return {1'b1, 32'h00100000};
      5: return {1'b1, (m_key == 16'hA05F) ? 32'h0001A05F : {16'd0, m_key}};
      7: return {1'b1, m_aux};
      8: return {1'b1, m_sdr};
      9: return {1'b1, m_init};
      12: return {1'b1, m_flg};
      14: return {1'b1, m_nvf};
      default: return {1'b0, 32'd0};
    endcase
  endfunction

  task automatic mwrite(input logic [11:0] a, input logic [31:0] d, output bit ok);
    int ix = int'(a >> 2);
    ok = 1;
    case (ix)
      2: if (m_key == 16'hA05F) m_osc = d;
      3: begin m_ctrl = {29'd0, d[2], 1'b0, d[0]}; e_rst = d[3]; end
      5: m_key = d[15:0];
      7: if (m_key == 16'hA05F) m_aux = d;
      8: m_sdr = d;
      9: m_init = d;
      12: m_flg = m_flg | d;
      13: m_flg = m_flg & ~d;
      14: m_nvf = m_nvf | d;
      15: m_nvf = m_nvf & ~d;
      32, 33, 34, 35: ;
      default: ok = 0;
    endcase
  endtask

  always @(posedge clk) begin
    logic [32:0] r;
    bit ok;
    if (!rst_n) begin
      m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_sdr = 32'h00011122;
      m_init = 32'h00000112; m_flg = 0; m_nvf = 0; m_ctrl = 0; m_key = 0;
      e_rd = 0; e_err = 0; e_rst = 0;
    end else begin
      e_rd = 0; e_err = 0; e_rst = 0;
      if (req_rd) begin r = mread(req_addr); e_rd = r[31:0]; e_err = !r[32]; end
      if (req_wr) begin mwrite(req_addr, req_wdata, ok); if (!ok) e_err = 1; end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      checks++;
      if (rsp_rdata !== e_rd || rsp_err !== e_err || rst_req !== e_rst ||
          remap_ram !== m_ctrl[2] || led_on !== m_ctrl[0]) begin
        errors++;
        $display("FAIL %s model: rdata=%h err=%b rst=%b remap=%b led=%b expected %h %b %b %b %b",
                 cur_req, rsp_rdata, rsp_err, rst_req, remap_ram, led_on,
                 e_rd, e_err, e_rst, m_ctrl[2], m_ctrl[0]);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    req_wr = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_wr = 0; req_wdata = 0;
  endtask

  task automatic do_rd(input logic [11:0] a, input string tag, input logic [31:0] exp);
    req_rd = 1; req_addr = a;
    @(negedge clk);
    req_rd = 0;
    chk(tag, rsp_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most 20000", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    cmp_en = 1;
    idle(1);
    // R12 reset state
    cur_req = "R12";
    chk("R12 remap_ram", {31'd0, remap_ram}, 32'd0);
    chk("R12 led_on", {31'd0, led_on}, 32'd0);
    do_rd(12'h008, "R12 osc", 32'h01000048);
    do_rd(12'h01C, "R12 aux", 32'h0007FEFF);
    do_rd(12'h020, "R12 sdram", 32'h00011122);
    do_rd(12'h024, "R12 init", 32'h00000112);
    do_rd(12'h00C, "R12 ctrl", 32'd0);
    do_rd(12'h014, "R12 key", 32'd0);
    do_rd(12'h030, "R12 flags", 32'd0);
    // R1 constants and idle zero
    cur_req = "R1";
    do_rd(12'h000, "R1 id", 32'h411A3001);
    do_rd(12'h004, "R1 proc", 32'd0);
    do_rd(12'h013, "R1 status low bits ignored", 32'h00100000);
    idle(1);
    chk("R1 idle data", rsp_rdata, 32'd0);
    // R3 locked write ignored, R2 key
    cur_req = "R3";
    do_wr(12'h008, 32'hDEADBEEF);
    do_rd(12'h008, "R3 osc locked", 32'h01000048);
    cur_req = "R2";
    do_wr(12'h014, 32'hFFFFA05F);
    do_rd(12'h014, "R2 key unlocked", 32'h0001A05F);
    cur_req = "R3";
    do_wr(12'h008, 32'h12345678);
    do_rd(12'h008, "R3 osc unlocked", 32'h12345678);
    do_wr(12'h01C, 32'hCAFE0001);
    do_rd(12'h01C, "R3 aux unlocked", 32'hCAFE0001);
    cur_req = "R2";
    do_wr(12'h014, 32'h00011234);
    do_rd(12'h014, "R2 key other", 32'h00001234);
    cur_req = "R3";
    do_wr(12'h01C, 32'h0);
    do_rd(12'h01C, "R3 aux relocked", 32'hCAFE0001);
    // R4 / R5 control
    cur_req = "R4";
    do_wr(12'h00C, 32'hFFFFFFF7);
    chk("R5 led_on", {31'd0, led_on}, 32'd1);
    chk("R5 remap_ram", {31'd0, remap_ram}, 32'd1);
    chk("R4 no rst_req", {31'd0, rst_req}, 32'd0);
    do_rd(12'h00C, "R4 ctrl bits", 32'h5);
    do_wr(12'h00C, 32'h8);
    chk("R4 rst_req pulse", {31'd0, rst_req}, 32'd1);
    chk("R5 remap back to flash", {31'd0, remap_ram}, 32'd0);
    idle(1);
    chk("R4 rst_req single", {31'd0, rst_req}, 32'd0);
    do_rd(12'h00C, "R4 reset bit not stored", 32'h0);
    // R6 / R7 flags
    cur_req = "R6";
    do_wr(12'h030, 32'h0000F0F0);
    do_wr(12'h030, 32'h00000F00);
    do_rd(12'h030, "R6 flags set", 32'h0000FFF0);
    do_wr(12'h034, 32'h000000F0);
    do_rd(12'h030, "R6 flags clear", 32'h0000FF00);
    cur_req = "R7";
    do_wr(12'h038, 32'hA0000005);
    do_wr(12'h03C, 32'h00000004);
    do_rd(12'h038, "R7 nvflags", 32'hA0000001);
    // R8
    cur_req = "R8";
    do_wr(12'h020, 32'hFFFFFFFF);
    do_rd(12'h020, "R8 sdram", 32'hFFFFFFFF);
    do_wr(12'h024, 32'h89ABCDEF);
    do_rd(12'h024, "R8 init", 32'h89ABCDEF);
    // R9 table window
    cur_req = "R9";
    do_rd(12'h100, "R9 entry0", 32'h80);
    do_rd(12'h108, "R9 entry2", 32'h04);
    do_rd(12'h124, "R9 entry9", 32'hA0);
    do_rd(12'h17C, "R9 entry31", 32'h02);
    do_rd(12'h180, "R9 upper zero", 32'h0);
    do_rd(12'h1FC, "R9 top zero", 32'h0);
    do_wr(12'h104, 32'h1);
    chk("R9 window write err", {31'd0, rsp_err}, 32'd1);
    // R10 voltage words
    cur_req = "R10";
    do_wr(12'h080, 32'hFFFFFFFF);
    chk("R10 write no err", {31'd0, rsp_err}, 32'd0);
    do_rd(12'h08C, "R10 read zero", 32'h0);
    // R11 unimplemented
    cur_req = "R11";
    do_rd(12'h018, "R11 read idx6 data", 32'h0);
    chk("R11 read idx6 err", {31'd0, rsp_err}, 32'd1);
    idle(1);
    chk("R11 err one cycle", {31'd0, rsp_err}, 32'd0);
    do_rd(12'h034, "R11 read clear addr", 32'h0);
    chk("R11 read clear addr err", {31'd0, rsp_err}, 32'd1);
    do_wr(12'h000, 32'hFFFFFFFF);
    chk("R11 write id err", {31'd0, rsp_err}, 32'd1);
    do_wr(12'h040, 32'hFFFFFFFF);
    do_wr(12'h200, 32'hFFFFFFFF);
    do_rd(12'h030, "R11 flags unchanged", 32'h0000FF00);
    do_rd(12'h024, "R11 init unchanged", 32'h89ABCDEF);
    do_rd(12'h400, "R11 far read", 32'h0);
    idle(2);
    finish_run();
  end
endmodule